// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Pinned Slots

This block caches virtual-to-physical page translations in a small, fully associative array. Each entry records its own page size. Sizes are powers of four, from 4 KB up to 4 GB. A lookup checks the virtual address against every valid entry at once. The compare skips the address bits that fall inside each entry's page, and those bits are copied unchanged into the physical address. The result appears one cycle after the lookup is accepted.

A low region of slots can be pinned by software so that replacement never touches them. Every other translation lands in a slot chosen by a rotating pointer, and that pointer steps over pinned slots. When a lookup misses, the block asks an external page walker for the translation and holds further lookups off until the walker answers. The walker answers with either a translation, which is installed and returned, or a fault.

The array has a single port, so it accepts one operation per cycle. When several operations arrive together, a fixed priority picks the one that is served.

Top module: `tlb_assoc`

## Requirements
- R1: After reset no entry is valid, and `rsp_valid`, `walk_req` and `busy` are 0.
- R2: A lookup accepted in cycle N that matches a valid entry gives `rsp_valid`=1, `rsp_hit`=1, `rsp_fault`=0 and the translated `rsp_pa` in cycle N+1.
- R3: Size code k (0 to 10) means a page of 2^(12+2k) bytes. Virtual address bits below that boundary are left out of the compare and are copied into `rsp_pa`. Above the boundary, `rsp_pa` takes the stored page number, and any stored page-number bits below the boundary are ignored.
- R4: When more than one valid entry matches, the entry with the lowest index supplies the result.
- R5: A lookup accepted in cycle N that matches no entry gives no response in cycle N+1. Instead it raises `walk_req` and `busy`, with `walk_va` equal to the looked-up address. Both stay asserted until `walk_ack`.
- R6: While `busy` is 1, lookups are ignored: they give no response and leave `walk_va` unchanged.
- R7: A `walk_ack` with `walk_fault`=0 installs the walker's translation in a replaceable slot. It answers the pending lookup in the next cycle with `rsp_hit`=1 and the translated address, and it drops `walk_req`. Later lookups to the same page hit.
- R8: A `walk_ack` with `walk_fault`=1 answers in the next cycle with `rsp_valid`=1, `rsp_fault`=1 and `rsp_hit`=0. It installs nothing.
- R9: An insert with `ins_pin`=1 writes slot `ins_slot` and marks it pinned, but only when `ins_slot` < PIN_MAX. If `ins_slot` is PIN_MAX or higher, the insert is ignored.
- R10: An insert with `ins_pin`=0, and any walker fill, goes to the first non-pinned slot found by counting upward (wrapping) from a pointer that starts at 0. The pointer then moves to the slot after the one used.
- R11: A one-cycle `purge` invalidates every non-pinned entry. Pinned entries stay valid.
- R12: Only one operation is served per cycle, in this priority order: a walker answer while busy, then purge, then insert, then lookup. A lookup that loses gives no response and starts no walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W (48) | Virtual address to translate |
| ins_valid | input | 1 | Insert request |
| ins_pin | input | 1 | 1: write a pinned slot; 0: write a replaceable slot |
| ins_slot | input | IDX_W | Target slot for a pinned insert |
| ins_vpn | input | VA_W-12 | Virtual page number to insert |
| ins_ppn | input | PA_W-12 | Physical page number to insert |
| ins_size | input | 4 | Page size code of the insert |
| purge | input | 1 | Invalidate all non-pinned entries |
| walk_ack | input | 1 | Walker answer strobe |
| walk_fault | input | 1 | Walker found no translation |
| walk_ppn | input | PA_W-12 | Physical page number from the walker |
| walk_size | input | 4 | Page size code from the walker |
| walk_req | output | 1 | Walk request pending |
| walk_va | output | VA_W (48) | Address the walker must translate |
| busy | output | 1 | Lookups are held off |
| rsp_valid | output | 1 | Lookup result valid this cycle |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Walker reported a fault |
| rsp_pa | output | PA_W (40) | Physical address |

## Verification
The vector table looks up addresses in 4 KB, 16 KB, 4 MB and 4 GB pages. Some addresses fall inside a page and some fall just past its end. Together they show whether the size mask is applied at the right bit for each code and whether the offset is carried through to the physical address. One 4 MB entry stores page-number bits below its boundary, which shows whether those bits are masked out. Directed cases cover several things:
- a pinned page that overlaps a smaller replaceable page, which exposes the wrong match priority;
- a miss followed by a second lookup while busy, then a fill and a fault, which separates the install path from the fault path;
- seven replaceable inserts around two pinned slots, followed by a purge, which shows whether the pointer skips pinned slots and whether purge spares them.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 48;
    localparam int PA_W   = 40;
    localparam int PG_MIN = 12;
    localparam int VPN_W  = VA_W - PG_MIN;
    localparam int PPN_W  = PA_W - PG_MIN;
    localparam int SZ_W   = 4;
    localparam int SZ_MAX = 10;

    typedef struct packed {
        logic             valid;
        logic             pinned;
        logic [SZ_W-1:0]  sz;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;

    // Ones on page-number bits that take part in the compare for a size code.
    function automatic logic [VPN_W-1:0] vpn_mask(input logic [SZ_W-1:0] sz);
        int sh;
        sh = (int'(sz) > SZ_MAX) ? 2 * SZ_MAX : 2 * int'(sz);
        return ~((VPN_W'(1) << sh) - VPN_W'(1));
    endfunction

    function automatic logic [PPN_W-1:0] ppn_mask(input logic [SZ_W-1:0] sz);
        int sh;
        sh = (int'(sz) > SZ_MAX) ? 2 * SZ_MAX : 2 * int'(sz);
        return ~((PPN_W'(1) << sh) - PPN_W'(1));
    endfunction

    // Physical address: stored page bits above the boundary, virtual bits below.
    function automatic logic [PA_W-1:0] build_pa(input logic [PPN_W-1:0] ppn,
                                                 input logic [SZ_W-1:0]  sz,
                                                 input logic [PA_W-1:0]  va);
        logic [PPN_W-1:0] m;
        m = ppn_mask(sz);
        return {(ppn & m) | (va[PA_W-1:PG_MIN] & ~m), va[PG_MIN-1:0]};
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 128,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  tlb_entry_t       ent_i [ENTRIES],
    input  logic [VPN_W-1:0] vpn_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_i[g].valid &&
                          (((ent_i[g].vpn ^ vpn_i) & vpn_mask(ent_i[g].sz)) == '0);
    end

    // Lowest matching index wins.
    always_comb begin
        hit_o = |match;
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 128,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] pinned_i,
    input  logic [IDX_W-1:0]   ptr_i,
    output logic [IDX_W-1:0]   victim_o,
    output logic [IDX_W-1:0]   next_ptr_o
);
    // First non-pinned slot at or after the pointer, wrapping.
    always_comb begin
        logic found;
        found    = 1'b0;
        victim_o = ptr_i;
        for (int j = 0; j < ENTRIES; j++) begin
            int k;
            k = (int'(ptr_i) + j) % ENTRIES;
            if (!found && !pinned_i[k]) begin
                victim_o = IDX_W'(k);
                found    = 1'b1;
            end
        end
        next_ptr_o = IDX_W'((int'(victim_o) + 1) % ENTRIES);
    end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 128,
    parameter int PIN_MAX = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             ins_valid,
    input  logic             ins_pin,
    input  logic [IDX_W-1:0] ins_slot,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [SZ_W-1:0]  ins_size,
    input  logic             purge,
    input  logic             walk_ack,
    input  logic             walk_fault,
    input  logic [PPN_W-1:0] walk_ppn,
    input  logic [SZ_W-1:0]  walk_size,
    output logic             walk_req,
    output logic [VA_W-1:0]  walk_va,
    output logic             busy,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_pa
);
    typedef struct packed {
        logic             walk_pend;
        logic [VA_W-1:0]  walk_va;
        logic [IDX_W-1:0] rr;
        logic             rsp_valid;
        logic             rsp_hit;
        logic             rsp_fault;
        logic [PA_W-1:0]  rsp_pa;
    } ctl_t;

    ctl_t               ctl_d, ctl_q;
    tlb_entry_t         ent_d [ENTRIES];
    tlb_entry_t         ent_q [ENTRIES];
    logic [ENTRIES-1:0] pinned_vec;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   victim, next_rr;
    logic               take_walk, do_purge, do_ins, do_lk;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_pin
        assign pinned_vec[g] = ent_q[g].pinned;
    end

    tlb_match #(.ENTRIES(ENTRIES)) u_match (
        .ent_i (ent_q),
        .vpn_i (lk_va[VA_W-1:PG_MIN]),
        .hit_o (hit),
        .idx_o (hit_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .pinned_i   (pinned_vec),
        .ptr_i      (ctl_q.rr),
        .victim_o   (victim),
        .next_ptr_o (next_rr)
    );

    // Single port arbitration: walker answer > purge > insert > lookup.
    assign take_walk = ctl_q.walk_pend && walk_ack;
    assign do_purge  = purge && !take_walk;
    assign do_ins    = ins_valid && !take_walk && !purge;
    assign do_lk     = lk_valid && !ctl_q.walk_pend && !purge && !ins_valid;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        ctl_d.rsp_hit   = 1'b0;
        ctl_d.rsp_fault = 1'b0;
        for (int i = 0; i < ENTRIES; i++) ent_d[i] = ent_q[i];

        if (take_walk) begin
            ctl_d.walk_pend = 1'b0;
            ctl_d.rsp_valid = 1'b1;
            if (walk_fault) begin
                ctl_d.rsp_fault = 1'b1;
            end else begin
                ent_d[victim] = '{valid: 1'b1, pinned: 1'b0, sz: walk_size,
                                  vpn: ctl_q.walk_va[VA_W-1:PG_MIN], ppn: walk_ppn};
                ctl_d.rr      = next_rr;
                ctl_d.rsp_hit = 1'b1;
                ctl_d.rsp_pa  = build_pa(walk_ppn, walk_size, ctl_q.walk_va[PA_W-1:0]);
            end
        end else if (do_purge) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!ent_q[i].pinned) ent_d[i].valid = 1'b0;
            end
        end else if (do_ins) begin
            if (ins_pin) begin
                if (int'(ins_slot) < PIN_MAX) begin
                    ent_d[ins_slot] = '{valid: 1'b1, pinned: 1'b1, sz: ins_size,
                                        vpn: ins_vpn, ppn: ins_ppn};
                end
            end else begin
                ent_d[victim] = '{valid: 1'b1, pinned: 1'b0, sz: ins_size,
                                  vpn: ins_vpn, ppn: ins_ppn};
                ctl_d.rr      = next_rr;
            end
        end else if (do_lk) begin
            if (hit) begin
                ctl_d.rsp_valid = 1'b1;
                ctl_d.rsp_hit   = 1'b1;
                ctl_d.rsp_pa    = build_pa(ent_q[hit_idx].ppn, ent_q[hit_idx].sz,
                                           lk_va[PA_W-1:0]);
            end else begin
                ctl_d.walk_pend = 1'b1;
                ctl_d.walk_va   = lk_va;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else begin
            ctl_q <= ctl_d;
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= ent_d[i];
        end
    end

    assign walk_req  = ctl_q.walk_pend;
    assign busy      = ctl_q.walk_pend;
    assign walk_va   = ctl_q.walk_va;
    assign rsp_valid = ctl_q.rsp_valid;
    assign rsp_hit   = ctl_q.rsp_hit;
    assign rsp_fault = ctl_q.rsp_fault;
    assign rsp_pa    = ctl_q.rsp_pa;

    AST_HIT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        do_lk && hit |=> rsp_valid && rsp_hit && !rsp_fault); // R2
    AST_MISS_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
        do_lk && !hit |=> walk_req && busy && !rsp_valid); // R5
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !walk_ack |=> busy && $stable(walk_va) && !rsp_valid); // R6
    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_hit && rsp_fault)); // R8
    AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_walk && !walk_fault) || (do_ins && !ins_pin) |-> !pinned_vec[victim]); // R10
    for (genvar g = 0; g < ENTRIES; g++) begin : g_keep
        AST_PIN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            ent_q[g].pinned |=> ent_q[g].pinned && ent_q[g].valid); // R11
    end
endmodule

// File: tb/tlb_assoc_tb.sv
module tlb_assoc_tb;
    import tlb_pkg::*;
    localparam int ENTRIES = 8;
    localparam int PIN_MAX = 4;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0, ins_valid = 1'b0, ins_pin = 1'b0, purge = 1'b0;
    logic             walk_ack = 1'b0, walk_fault = 1'b0;
    logic [VA_W-1:0]  lk_va = '0;
    logic [IDX_W-1:0] ins_slot = '0;
    logic [VPN_W-1:0] ins_vpn = '0;
    logic [PPN_W-1:0] ins_ppn = '0, walk_ppn = '0;
    logic [SZ_W-1:0]  ins_size = '0, walk_size = '0;
    logic             walk_req, busy, rsp_valid, rsp_hit, rsp_fault;
    logic [VA_W-1:0]  walk_va;
    logic [PA_W-1:0]  rsp_pa;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tlb_assoc #(.ENTRIES(ENTRIES), .PIN_MAX(PIN_MAX)) u_dut (
        .clk, .rst_n, .lk_valid, .lk_va, .ins_valid, .ins_pin, .ins_slot,
        .ins_vpn, .ins_ppn, .ins_size, .purge, .walk_ack, .walk_fault,
        .walk_ppn, .walk_size, .walk_req, .walk_va, .busy, .rsp_valid,
        .rsp_hit, .rsp_fault, .rsp_pa
    );

    typedef struct packed {
        logic            is_lk;
        logic            pin;
        logic [2:0]      slot;
        logic [3:0]      sz;
        logic [47:0]     va;
        logic [39:0]     pa;
        logic            exp_hit;
    } vec_t;

    // Inserts carry page base addresses; lookups carry the expected physical address.
    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 3'd0, 4'd10, 48'h0012_0000_0000, 40'h55_0000_0000, 1'b0},
        '{1'b0, 1'b1, 3'd2, 4'd1,  48'h0000_4000_0000, 40'h77_0000_0000, 1'b0},
        '{1'b0, 1'b0, 3'd0, 4'd0,  48'h0000_0000_5000, 40'h01_2345_6000, 1'b0},
        '{1'b1, 1'b0, 3'd0, 4'd0,  48'h0012_89AB_CDEF, 40'h55_89AB_CDEF, 1'b1},
        '{1'b1, 1'b0, 3'd0, 4'd0,  48'h0013_0000_0000, 40'h0,            1'b0},
        '{1'b1, 1'b0, 3'd0, 4'd0,  48'h0000_4000_3ABC, 40'h77_0000_3ABC, 1'b1},
        '{1'b1, 1'b0, 3'd0, 4'd0,  48'h0000_4000_4000, 40'h0,            1'b0},
        '{1'b1, 1'b0, 3'd0, 4'd0,  48'h0000_0000_5FFF, 40'h01_2345_6FFF, 1'b1},
        '{1'b1, 1'b0, 3'd0, 4'd0,  48'h0000_0000_6000, 40'h0,            1'b0},
        '{1'b0, 1'b0, 3'd0, 4'd5,  48'h0000_8000_0000, 40'h33_0012_3000, 1'b0},
        '{1'b1, 1'b0, 3'd0, 4'd0,  48'h0000_803F_FFFF, 40'h33_003F_FFFF, 1'b1},
        '{1'b1, 1'b0, 3'd0, 4'd0,  48'h0000_8040_0000, 40'h0,            1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_ins(input logic pin, input logic [IDX_W-1:0] slot,
                          input logic [47:0] va, input logic [39:0] pa, input logic [3:0] sz);
        ins_valid = 1'b1; ins_pin = pin; ins_slot = slot;
        ins_vpn = va[47:12]; ins_ppn = pa[39:12]; ins_size = sz;
        @(negedge clk);
        ins_valid = 1'b0; ins_pin = 1'b0;
    endtask

    task automatic do_purge();
        purge = 1'b1;
        @(negedge clk);
        purge = 1'b0;
    endtask

    // Hit: response next cycle. Miss: walk raised, answered with a fault.
    task automatic do_lk(input string tag, input logic [47:0] va,
                         input logic exp_hit, input logic [39:0] exp_pa);
        lk_valid = 1'b1; lk_va = va;
        @(negedge clk);
        lk_valid = 1'b0;
        if (exp_hit) begin
            chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
            chk({tag, " rsp_hit"},   64'(rsp_hit),   64'd1);
            chk({tag, " rsp_pa"},    64'(rsp_pa),    64'(exp_pa));
        end else begin
            chk({tag, " miss rsp_valid"}, 64'(rsp_valid), 64'd0);
            chk({tag, " miss walk_req"},  64'(walk_req),  64'd1);
            chk({tag, " miss walk_va"},   64'(walk_va),   64'(va));
            walk_ack = 1'b1; walk_fault = 1'b1;
            @(negedge clk);
            walk_ack = 1'b0; walk_fault = 1'b0;
            chk({tag, " fault rsp_fault"}, 64'(rsp_fault), 64'd1);
            chk({tag, " fault rsp_hit"},   64'(rsp_hit),   64'd0);
            chk({tag, " fault busy"},      64'(busy),      64'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 walk_req",  64'(walk_req),  64'd0);
        chk("R1 busy",      64'(busy),      64'd0);

        // R2 R3: vector table over several page sizes
        for (int v = 0; v < NV; v++) begin
            if (VEC[v].is_lk) do_lk($sformatf("R2/R3 vec%0d", v), VEC[v].va, VEC[v].exp_hit, VEC[v].pa);
            else do_ins(VEC[v].pin, IDX_W'(VEC[v].slot), VEC[v].va, VEC[v].pa, VEC[v].sz);
        end

        // R1: after reset the earlier 4 GB page is gone
        do_reset();
        do_lk("R1 empty", 48'h0012_89AB_CDEF, 1'b0, 40'h0);

        // R4: overlap, lowest index wins (pinned slot 1 vs replaceable slot 0)
        do_reset();
        do_ins(1'b1, 3'd1, 48'h0000_0001_0000, 40'h0A_0000_0000, 4'd1);
        do_ins(1'b0, 3'd0, 48'h0000_0001_2000, 40'h0B_0000_0000, 4'd0);
        do_lk("R4 overlap", 48'h0000_0001_2345, 1'b1, 40'h0B_0000_0345);
        do_lk("R4 single",  48'h0000_0001_1345, 1'b1, 40'h0A_0000_1345);

        // R5 R6 R7: miss, busy, fill
        do_reset();
        lk_valid = 1'b1; lk_va = 48'h0000_0009_1234;
        @(negedge clk);
        lk_va = 48'h0000_0000_7000;
        chk("R5 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R5 walk_req",  64'(walk_req),  64'd1);
        chk("R5 busy",      64'(busy),      64'd1);
        chk("R5 walk_va",   64'(walk_va),   64'h0000_0009_1234);
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R6 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R6 walk_va",   64'(walk_va),   64'h0000_0009_1234);
        chk("R6 still busy", 64'(busy),     64'd1);
        walk_ack = 1'b1; walk_fault = 1'b0; walk_ppn = 28'h440_0000; walk_size = 4'd0;
        @(negedge clk);
        walk_ack = 1'b0;
        chk("R7 rsp_valid", 64'(rsp_valid), 64'd1);
        chk("R7 rsp_hit",   64'(rsp_hit),   64'd1);
        chk("R7 rsp_pa",    64'(rsp_pa),    64'h44_0000_0234);
        chk("R7 walk_req",  64'(walk_req),  64'd0);
        do_lk("R7 refill hit", 48'h0000_0009_1ABC, 1'b1, 40'h44_0000_0ABC);

        // R8: fault installs nothing (second lookup misses again)
        do_lk("R8 fault a", 48'h0000_00AA_0000, 1'b0, 40'h0);
        do_lk("R8 fault b", 48'h0000_00AA_0000, 1'b0, 40'h0);

        // R9: pinned slot outside the pinnable region is ignored
        do_ins(1'b1, 3'd5, 48'h0000_00C0_0000, 40'h12_0000_0000, 4'd0);
        do_lk("R9 bad slot", 48'h0000_00C0_0000, 1'b0, 40'h0);

        // R10 R11: round robin skips pinned slots, purge spares them
        do_reset();
        do_ins(1'b1, 3'd1, 48'h0000_1000_0000, 40'h61_0000_0000, 4'd0);
        do_ins(1'b1, 3'd2, 48'h0000_2000_0000, 40'h62_0000_0000, 4'd0);
        for (int k = 0; k < 7; k++)
            do_ins(1'b0, 3'd0, 48'h0000_3000_0000 + 48'(k) * 48'h1000,
                   40'h20_0000_0000 + 40'(k) * 40'h1000, 4'd0);
        do_lk("R10 pinned1", 48'h0000_1000_0010, 1'b1, 40'h61_0000_0010);
        do_lk("R10 pinned2", 48'h0000_2000_0020, 1'b1, 40'h62_0000_0020);
        for (int k = 1; k < 7; k++)
            do_lk($sformatf("R10 kept%0d", k), 48'h0000_3000_0000 + 48'(k) * 48'h1000,
                  1'b1, 40'h20_0000_0000 + 40'(k) * 40'h1000);
        do_lk("R10 evicted", 48'h0000_3000_0000, 1'b0, 40'h0);
        do_purge();
        do_lk("R11 pinned survives", 48'h0000_1000_0ABC, 1'b1, 40'h61_0000_0ABC);
        do_lk("R11 purged", 48'h0000_3000_3000, 1'b0, 40'h0);

        // R12: insert and purge win over a same-cycle lookup
        do_reset();
        do_ins(1'b0, 3'd0, 48'h0000_0050_0000, 40'h0C_0000_0000, 4'd0);
        ins_valid = 1'b1; ins_pin = 1'b0; ins_vpn = 36'h00000_0060; ins_ppn = 28'h0D0_0000;
        ins_size = 4'd0; lk_valid = 1'b1; lk_va = 48'h0000_0050_0000;
        @(negedge clk);
        ins_valid = 1'b0; lk_valid = 1'b0;
        chk("R12 ins wins rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R12 ins wins walk_req",  64'(walk_req),  64'd0);
        do_lk("R12 insert done", 48'h0000_0006_0004, 1'b1, 40'h0D_0000_0004);
        purge = 1'b1; lk_valid = 1'b1; lk_va = 48'h0000_0006_0004;
        @(negedge clk);
        purge = 1'b0; lk_valid = 1'b0;
        chk("R12 purge wins rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R12 purge wins walk_req",  64'(walk_req),  64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule